// File: doc/BRIEF.md
# Host-to-Microcontroller Command Mailbox

This block is the register window between a host processor and an auxiliary system microcontroller. The host reaches it over a 32-bit request/response register bus. Through it the host stages up to four words of input data and two pointer words, then writes a command word. That write marks the mailbox busy and sends a one-cycle command interrupt to the microcontroller. The decoded command fields, the staged words and the pointers are always visible on the microcontroller side.

The microcontroller places its results in a four-word result buffer. It then signals completion together with an error flag, an error code and an initiator id. The mailbox latches these into the status word and echoes the sub-type of the accepted command there. It drops busy, and if the command asked for it, it pulses a completion interrupt to the host. The host polls busy in the status word before it reads the result buffer.

Host bus rules: `req_ready` is held high, so the block never stalls a request. Every request is taken in the cycle `req_valid` is high. A read returns `rsp_valid` with `rsp_rdata` exactly one cycle later. Writes produce no response. The response side has no ready because the block never holds back read data.

Top module: `mbox_ipc`

## Requirements
- R1: After reset every host-visible location reads zero, the status word is zero, `mcu_in_word` is zero, and both `mcu_cmd_irq` and `host_done_irq` are low.
- R2: A write to byte address 0x00 while idle is accepted. On the next clock edge, status bit 0 (busy) is set and `mcu_cmd_irq` is high for exactly one cycle. The command fields come out of the write data: code from bits [7:0], completion-interrupt request from bit 8, sub-type from bits [15:12] and data size from bits [23:16].
- R3: A command write while busy is set is discarded: no interrupt is raised and the command fields keep their values.
- R4: Reads of the command address 0x00 and of any unmapped address return zero. Every read is answered one cycle after the request.
- R5: The write buffer (0x80, 0x84, 0x88, 0x8C) and the pointers (source 0x08, destination 0x0C) take a write only when all four byte enables are set. A write with fewer enables leaves the word unchanged. The stored words can be read back by the host and are visible to the microcontroller.
- R6: Host writes to the status word (0x04), to the result buffer or to unmapped addresses change nothing.
- R7: Completion while busy clears busy. The status word then reads {8'h00, error code, initiator id, command sub-type, 2'b00, error, busy}, with the error code in bits [23:16], the initiator in [15:8], the sub-type in [7:4] and the error flag in bit 1.
- R8: `host_done_irq` pulses for one cycle after completion only if the accepted command had bit 8 set.
- R9: A microcontroller write to result word k appears at host address 0x90 + 4k.
- R10: Completion while idle is ignored: the status word is unchanged and no host interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Always high, requests never stall |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables of a write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| mcu_cmd_irq | output | 1 | One-cycle pulse per accepted command |
| mcu_cmd_code | output | 8 | Command code |
| mcu_cmd_ioc | output | 1 | Completion interrupt requested |
| mcu_cmd_sub | output | 4 | Command sub-type |
| mcu_cmd_size | output | 8 | Input data size |
| mcu_src_ptr | output | 32 | Source pointer word |
| mcu_dst_ptr | output | 32 | Destination pointer word |
| mcu_in_idx | input | log2(BUF_WORDS) | Write-buffer word select |
| mcu_in_word | output | 32 | Selected write-buffer word |
| mcu_out_we | input | 1 | Result-buffer write strobe |
| mcu_out_idx | input | log2(BUF_WORDS) | Result-buffer word select |
| mcu_out_data | input | 32 | Result data |
| mcu_done | input | 1 | Completion strobe |
| mcu_err | input | 1 | Completion failed |
| mcu_err_code | input | 8 | Reason for failure |
| mcu_init_id | input | 8 | Initiator id |
| host_done_irq | output | 1 | One-cycle completion interrupt to the host |

## Verification
The hardest case is a second command that arrives while the first is still busy. This cannot happen unless the microcontroller side holds off completion. The stimulus therefore keeps `mcu_done` low and writes the command address again with different fields. It then checks that no interrupt follows and that the decoded fields stay the same. Completion while idle is reached by pulsing `mcu_done` after a finished command and reading status back. Partial-enable writes come from the vector table, followed by read-back.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [2:0] {
    LOC_NONE, LOC_CMD, LOC_STAT, LOC_SRC, LOC_DST, LOC_WBUF, LOC_RBUF
  } loc_e;

  typedef struct packed {
    logic [7:0] size;
    logic [3:0] sub;
    logic       ioc;
    logic [7:0] code;
  } cmd_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  parameter int WBUF_BASE = 'h80
) (
  input  logic [ADDR_W-1:0]            addr,
  output loc_e                         loc,
  output logic [$clog2(BUF_WORDS)-1:0] idx
);
  localparam int IDX_W  = $clog2(BUF_WORDS);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] WB_LO = WORD_W'(WBUF_BASE / 4);
  localparam logic [WORD_W-1:0] WB_HI = WORD_W'(WBUF_BASE / 4 + BUF_WORDS);
  localparam logic [WORD_W-1:0] RB_HI = WORD_W'(WBUF_BASE / 4 + 2 * BUF_WORDS);

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    loc = LOC_NONE;
    idx = '0;
    if (word == WORD_W'(0))      loc = LOC_CMD;
    else if (word == WORD_W'(1)) loc = LOC_STAT;
    else if (word == WORD_W'(2)) loc = LOC_SRC;
    else if (word == WORD_W'(3)) loc = LOC_DST;
    else if (word >= WB_LO && word < WB_HI) begin
      loc = LOC_WBUF;
      idx = IDX_W'(word - WB_LO);
    end else if (word >= WB_HI && word < RB_HI) begin
      loc = LOC_RBUF;
      idx = IDX_W'(word - WB_HI);
    end
  end
endmodule

// File: rtl/mbox_bufs.sv
module mbox_bufs
  import mbox_pkg::*;
#(
  parameter int BUF_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_wr,
  input  loc_e                         host_loc,
  input  logic [$clog2(BUF_WORDS)-1:0] host_idx,
  input  logic [3:0]                   host_be,
  input  logic [31:0]                  host_wdata,
  input  logic                         mcu_we,
  input  logic [$clog2(BUF_WORDS)-1:0] mcu_widx,
  input  logic [31:0]                  mcu_wdata,
  input  logic [$clog2(BUF_WORDS)-1:0] mcu_ridx,
  output logic [31:0]                  wbuf_host,
  output logic [31:0]                  rbuf_host,
  output logic [31:0]                  wbuf_mcu,
  output logic [31:0]                  src_ptr,
  output logic [31:0]                  dst_ptr
);
  localparam int IDX_W = $clog2(BUF_WORDS);

  logic [31:0] wbuf [BUF_WORDS];
  logic [31:0] rbuf [BUF_WORDS];
  logic        full;
  assign full = host_wr && (host_be == 4'hF);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_ptr <= '0;
      dst_ptr <= '0;
    end else begin
      if (full && host_loc == LOC_SRC) src_ptr <= host_wdata;
      if (full && host_loc == LOC_DST) dst_ptr <= host_wdata;
    end
  end

  for (genvar i = 0; i < BUF_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) wbuf[i] <= '0;
      else if (full && host_loc == LOC_WBUF && host_idx == IDX_W'(i))
        wbuf[i] <= host_wdata;
    end

    always_ff @(posedge clk) begin
      if (rst) rbuf[i] <= '0;
      else if (mcu_we && mcu_widx == IDX_W'(i))
        rbuf[i] <= mcu_wdata;
    end

    // R5
    part_write_chk: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_loc == LOC_WBUF && host_idx == IDX_W'(i) && host_be != 4'hF)
      |=> $stable(wbuf[i]));

    // R6
    rbuf_host_chk: assert property (@(posedge clk) disable iff (rst)
      (host_wr && host_loc == LOC_RBUF && !mcu_we) |=> $stable(rbuf[i]));
  end

  assign wbuf_host = wbuf[host_idx];
  assign rbuf_host = rbuf[host_idx];
  assign wbuf_mcu  = wbuf[mcu_ridx];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        done_in,
  input  logic        err_in,
  input  logic [7:0]  err_code_in,
  input  logic [7:0]  init_in,
  output logic        busy,
  output cmd_t        cmd_q,
  output logic [31:0] status,
  output logic        cmd_irq,
  output logic        done_irq
);
  logic       err_q;
  logic [7:0] code_q;
  logic [7:0] init_q;
  logic [3:0] id_q;
  logic       accept;
  logic       finish;

  assign accept = cmd_wr && !busy;
  assign finish = done_in && busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cmd_q    <= '0;
      err_q    <= 1'b0;
      code_q   <= '0;
      init_q   <= '0;
      id_q     <= '0;
      cmd_irq  <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      cmd_irq  <= accept;
      done_irq <= finish && cmd_q.ioc;
      if (accept) begin
        busy  <= 1'b1;
        cmd_q <= cmd_t'({cmd_wdata[23:16], cmd_wdata[15:12], cmd_wdata[8], cmd_wdata[7:0]});
      end else if (finish) begin
        busy   <= 1'b0;
        err_q  <= err_in;
        code_q <= err_code_in;
        init_q <= init_in;
        id_q   <= cmd_q.sub;
      end
    end
  end

  assign status = {8'h00, code_q, init_q, id_q, 2'b00, err_q, busy};

  // R2
  irq_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_irq |-> busy);

  // R3
  busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr && !done_in) |=> (!cmd_irq && $stable(cmd_q)));

  // R7
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && done_in) |=> !busy);

  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && done_in && !cmd_wr) |=> ($stable(status) && !done_irq));

  // R8
  done_irq_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (!busy && !cmd_irq));
endmodule

// File: rtl/mbox_ipc.sv
module mbox_ipc
  import mbox_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUF_WORDS = 4,
  parameter int WBUF_BASE = 'h80
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [3:0]                   req_be,
  input  logic [31:0]                  req_wdata,
  output logic                         rsp_valid,
  output logic [31:0]                  rsp_rdata,
  output logic                         mcu_cmd_irq,
  output logic [7:0]                   mcu_cmd_code,
  output logic                         mcu_cmd_ioc,
  output logic [3:0]                   mcu_cmd_sub,
  output logic [7:0]                   mcu_cmd_size,
  output logic [31:0]                  mcu_src_ptr,
  output logic [31:0]                  mcu_dst_ptr,
  input  logic [$clog2(BUF_WORDS)-1:0] mcu_in_idx,
  output logic [31:0]                  mcu_in_word,
  input  logic                         mcu_out_we,
  input  logic [$clog2(BUF_WORDS)-1:0] mcu_out_idx,
  input  logic [31:0]                  mcu_out_data,
  input  logic                         mcu_done,
  input  logic                         mcu_err,
  input  logic [7:0]                   mcu_err_code,
  input  logic [7:0]                   mcu_init_id,
  output logic                         host_done_irq
);
  localparam int IDX_W = $clog2(BUF_WORDS);

  loc_e              loc;
  logic [IDX_W-1:0]  idx;
  logic              host_wr;
  logic              busy;
  cmd_t              cmd_q;
  logic [31:0]       status;
  logic [31:0]       wbuf_host;
  logic [31:0]       rbuf_host;
  logic [31:0]       rd_mux;

  assign req_ready = 1'b1;
  assign host_wr   = req_valid && req_write;

  mbox_decode #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS), .WBUF_BASE(WBUF_BASE)) u_dec (
    .addr (req_addr),
    .loc  (loc),
    .idx  (idx)
  );

  mbox_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (host_wr && loc == LOC_CMD),
    .cmd_wdata   (req_wdata),
    .done_in     (mcu_done),
    .err_in      (mcu_err),
    .err_code_in (mcu_err_code),
    .init_in     (mcu_init_id),
    .busy        (busy),
    .cmd_q       (cmd_q),
    .status      (status),
    .cmd_irq     (mcu_cmd_irq),
    .done_irq    (host_done_irq)
  );

  mbox_bufs #(.BUF_WORDS(BUF_WORDS)) u_bufs (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_loc   (loc),
    .host_idx   (idx),
    .host_be    (req_be),
    .host_wdata (req_wdata),
    .mcu_we     (mcu_out_we),
    .mcu_widx   (mcu_out_idx),
    .mcu_wdata  (mcu_out_data),
    .mcu_ridx   (mcu_in_idx),
    .wbuf_host  (wbuf_host),
    .rbuf_host  (rbuf_host),
    .wbuf_mcu   (mcu_in_word),
    .src_ptr    (mcu_src_ptr),
    .dst_ptr    (mcu_dst_ptr)
  );

  always_comb begin
    case (loc)
      LOC_STAT: rd_mux = status;
      LOC_SRC:  rd_mux = mcu_src_ptr;
      LOC_DST:  rd_mux = mcu_dst_ptr;
      LOC_WBUF: rd_mux = wbuf_host;
      LOC_RBUF: rd_mux = rbuf_host;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
    end
  end

  assign mcu_cmd_code = cmd_q.code;
  assign mcu_cmd_ioc  = cmd_q.ioc;
  assign mcu_cmd_sub  = cmd_q.sub;
  assign mcu_cmd_size = cmd_q.size;

  // R4
  read_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R4
  no_write_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R2
  busy_status_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(loc == LOC_STAT)) |-> (rsp_rdata[0] == $past(busy)));
endmodule

// File: tb/mbox_ipc_tb.sv
module mbox_ipc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mcu_cmd_irq, mcu_cmd_ioc, host_done_irq;
  logic [7:0]  mcu_cmd_code, mcu_cmd_size;
  logic [3:0]  mcu_cmd_sub;
  logic [31:0] mcu_src_ptr, mcu_dst_ptr, mcu_in_word;
  logic [1:0]  mcu_in_idx = '0, mcu_out_idx = '0;
  logic        mcu_out_we = 1'b0;
  logic [31:0] mcu_out_data = '0;
  logic        mcu_done = 1'b0, mcu_err = 1'b0;
  logic [7:0]  mcu_err_code = '0, mcu_init_id = '0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_ipc u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mcu_cmd_irq(mcu_cmd_irq), .mcu_cmd_code(mcu_cmd_code), .mcu_cmd_ioc(mcu_cmd_ioc),
    .mcu_cmd_sub(mcu_cmd_sub), .mcu_cmd_size(mcu_cmd_size),
    .mcu_src_ptr(mcu_src_ptr), .mcu_dst_ptr(mcu_dst_ptr),
    .mcu_in_idx(mcu_in_idx), .mcu_in_word(mcu_in_word),
    .mcu_out_we(mcu_out_we), .mcu_out_idx(mcu_out_idx), .mcu_out_data(mcu_out_data),
    .mcu_done(mcu_done), .mcu_err(mcu_err), .mcu_err_code(mcu_err_code),
    .mcu_init_id(mcu_init_id), .host_done_irq(host_done_irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'h80, 4'hF, 32'hDEADBEEF, 4'd5},
    '{1'b1, 8'h84, 4'hF, 32'h11112222, 4'd5},
    '{1'b1, 8'h88, 4'hF, 32'h33334444, 4'd5},
    '{1'b1, 8'h8C, 4'hF, 32'h55556666, 4'd5},
    '{1'b1, 8'h08, 4'hF, 32'hA0A0A0A0, 4'd5},
    '{1'b1, 8'h0C, 4'hF, 32'h0B0B0B0B, 4'd5},
    '{1'b0, 8'h80, 4'h0, 32'hDEADBEEF, 4'd5},
    '{1'b0, 8'h8C, 4'h0, 32'h55556666, 4'd5},
    '{1'b0, 8'h08, 4'h0, 32'hA0A0A0A0, 4'd5},
    '{1'b0, 8'h0C, 4'h0, 32'h0B0B0B0B, 4'd5},
    '{1'b1, 8'h84, 4'h3, 32'hFFFFFFFF, 4'd5},
    '{1'b0, 8'h84, 4'h0, 32'h11112222, 4'd5},
    '{1'b1, 8'h04, 4'hF, 32'hFFFFFFFF, 4'd6},
    '{1'b0, 8'h04, 4'h0, 32'h00000000, 4'd6},
    '{1'b1, 8'h94, 4'hF, 32'h12345678, 4'd6},
    '{1'b0, 8'h94, 4'h0, 32'h00000000, 4'd6},
    '{1'b1, 8'h40, 4'hF, 32'h77777777, 4'd6},
    '{1'b0, 8'h40, 4'h0, 32'h00000000, 4'd4},
    '{1'b0, 8'h00, 4'h0, 32'h00000000, 4'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'h0;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hXXXXXXXX;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    host_rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic finish_cmd(input logic e, input logic [7:0] code, input logic [7:0] init);
    @(negedge clk);
    mcu_done = 1'b1; mcu_err = e; mcu_err_code = code; mcu_init_id = init;
    @(negedge clk);
    mcu_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_irq", {31'b0, mcu_cmd_irq}, 32'h0);
    chk("R1 done_irq", {31'b0, host_done_irq}, 32'h0);
    chk("R1 mcu_in_word", mcu_in_word, 32'h0);
    rd_chk("R1 status", 8'h04, 32'h0);
    rd_chk("R1 wbuf0", 8'h80, 32'h0);
    rd_chk("R1 rbuf0", 8'h90, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) host_wr(VEC[i].addr, VEC[i].be, VEC[i].data);
      else rd_chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].data);
    end

    // R5 microcontroller view of staged data
    mcu_in_idx = 2'd2;
    @(negedge clk);
    chk("R5 mcu_in_word", mcu_in_word, 32'h33334444);
    chk("R5 src_ptr", mcu_src_ptr, 32'hA0A0A0A0);
    chk("R5 dst_ptr", mcu_dst_ptr, 32'h0B0B0B0B);

    // R2 command issue: size 0x10, sub 5, ioc, code 0x3C
    host_wr(8'h00, 4'hF, 32'h0010_513C);
    chk("R2 cmd_irq", {31'b0, mcu_cmd_irq}, 32'h1);
    chk("R2 fields", {7'b0, mcu_cmd_ioc, mcu_cmd_size, 4'b0, mcu_cmd_sub, mcu_cmd_code},
        32'h0110_053C);
    @(negedge clk);
    chk("R2 irq one cycle", {31'b0, mcu_cmd_irq}, 32'h0);
    rd_chk("R2 busy", 8'h04, 32'h0000_0001);

    // R3 command while busy
    host_wr(8'h00, 4'hF, 32'h0000_0077);
    chk("R3 no irq", {31'b0, mcu_cmd_irq}, 32'h0);
    chk("R3 code kept", {24'b0, mcu_cmd_code}, 32'h3C);

    // R9 result buffer
    @(negedge clk);
    mcu_out_we = 1'b1; mcu_out_idx = 2'd1; mcu_out_data = 32'hCAFEF00D;
    @(negedge clk);
    mcu_out_idx = 2'd3; mcu_out_data = 32'h0BADC0DE;
    @(negedge clk);
    mcu_out_we = 1'b0;
    rd_chk("R9 rbuf1", 8'h94, 32'hCAFEF00D);
    rd_chk("R9 rbuf3", 8'h9C, 32'h0BADC0DE);

    // R7 / R8 completion with error
    finish_cmd(1'b1, 8'h42, 8'h07);
    chk("R8 done_irq", {31'b0, host_done_irq}, 32'h1);
    @(negedge clk);
    chk("R8 irq one cycle", {31'b0, host_done_irq}, 32'h0);
    rd_chk("R7 status", 8'h04, 32'h0042_0752);

    // R10 completion while idle
    finish_cmd(1'b0, 8'h99, 8'h11);
    chk("R10 no irq", {31'b0, host_done_irq}, 32'h0);
    rd_chk("R10 status", 8'h04, 32'h0042_0752);

    // R8 no interrupt when not requested; R7 error cleared
    host_wr(8'h00, 4'hF, 32'h0000_2001);
    chk("R2 second accept", {31'b0, mcu_cmd_irq}, 32'h1);
    finish_cmd(1'b0, 8'h00, 8'h03);
    chk("R8 no ioc", {31'b0, host_done_irq}, 32'h0);
    rd_chk("R7 status clear", 8'h04, 32'h0000_0320);
    rd_chk("R4 cmd read", 8'h00, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule